// File: doc/BRIEF.md
# Window Alarm and Scan Pacing Controller

The block sets the pace for automatic conversions across a small group of input channels. It compares each tagged result against that channel's lower and upper limits and holds a per-channel alarm. From those alarms it drives an interrupt pin that can be pulled low or left floating. A pacing state machine issues a one-cycle start strobe together with the channel to convert. The interval between strobes is a base period doubled once for each step of a 3-bit delay code. Channels are visited from 0 up to a selectable last channel, and then the scan starts again at 0.

Results come back with a channel tag and a valid strobe. A result strictly below its lower limit or strictly above its upper limit latches that channel's alarm. The alarm stays set until a per-channel clear pulse or an alert-acknowledge pulse removes it. The alarm vector is visible at all times. The interrupt output enable is active only while interrupts are enabled and at least one alarm is held. When the enable is active the pin value is low; otherwise the pin floats.

Pacing state machine states, declared in the package:
- `ST_IDLE`: the reset state. It always moves to `ST_LAUNCH` on the next cycle.
- `ST_LAUNCH`: drives the start strobe for the current channel. In this cycle it samples the delay code and the last channel. It then moves to `ST_PACE`.
- `ST_PACE`: counts down the rest of the interval. When the count reaches zero it moves to `ST_LAUNCH`; otherwise it stays in `ST_PACE`.

Top module: `winmon_ctrl`

## Requirements
- R1: Consecutive `conv_start` pulses are exactly `BASE_CYC << delay_code` clock cycles apart. Code 0 gives the shortest interval, and each increment of the code doubles it.
- R2: `conv_start` is low during reset and is never high for two cycles in a row. The first pulse comes on the second rising edge after reset is released, with `conv_ch` = 0.
- R3: The channel reported with each start follows the previous one: it is 0 if the previous channel was greater than or equal to `last_ch`, and otherwise it is the previous channel plus 1.
- R4: The delay code is sampled in the cycle in which `conv_start` is high. A change while an interval is in progress takes effect from the next interval.
- R5: The alarm for channel `res_ch` is set one cycle after a `res_valid` result whose unsigned value is below that channel's lower limit or above its upper limit. Values equal to either limit do not set the alarm. Channel i's limits sit at bits `[i*DW +: DW]` of `lo_thr` and `hi_thr`.
- R6: An alarm stays set when later in-window results arrive for its channel.
- R7: A 1 in bit i of `alarm_clr` clears alarm i on the next cycle. A 0 bit leaves that alarm unchanged.
- R8: When a set and a clear for the same channel arrive in the same cycle, the alarm ends up set.
- R9: A pulse on `alert_ack` clears every alarm on the next cycle, except a channel being set in that same cycle. The interrupt therefore deasserts.
- R10: `irq_oe` is high exactly when `int_en` is 1 and at least one alarm is held. `irq_level` is always 0, so the pin is pulled low or floats.
- R11: `alarm_stat` shows the latched alarms whatever the value of `int_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| delay_code | input | CODE_W | Pacing rate code |
| last_ch | input | CHW | Highest channel in the scan |
| int_en | input | 1 | Interrupt enable |
| alarm_clr | input | NCH | Per-channel alarm clear pulses |
| alert_ack | input | 1 | Alert acknowledge pulse, clears all alarms |
| lo_thr | input | NCH*DW | Lower limits, channel i at `[i*DW +: DW]` |
| hi_thr | input | NCH*DW | Upper limits, channel i at `[i*DW +: DW]` |
| res_valid | input | 1 | Conversion result strobe |
| res_ch | input | CHW | Channel tag of the result |
| res_data | input | DW | Result value, unsigned |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_ch | output | CHW | Channel to convert, valid with `conv_start` |
| alarm_stat | output | NCH | Latched alarm vector |
| irq_oe | output | 1 | Interrupt pin drive enable |
| irq_level | output | 1 | Interrupt pin value when driven (0) |

## Verification
The bench builds the block with NCH=4, DW=10 and BASE_CYC=4. The longest interval is therefore 512 cycles. This makes it practical to measure every one of the eight delay codes twice each, and to sweep every `last_ch` setting through several wraps. With four 10-bit channels, each channel can be driven with values at, just inside and just outside both of its limits, plus the extremes 0 and 1023. It also allows set, clear and acknowledge pulses to be combined on chosen channels in the same cycle.

// File: rtl/winmon_pkg.sv
package winmon_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_PACE   = 2'd2
    } pace_state_e;

endpackage

// File: rtl/winmon_pacer.sv
module winmon_pacer
    import winmon_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int BASE_CYC = 4,
    parameter int CODE_W   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CODE_W-1:0]      delay_code,
    input  logic [$clog2(NCH)-1:0] last_ch,
    output logic                   conv_start,
    output logic [$clog2(NCH)-1:0] conv_ch
);
    localparam int CHW   = $clog2(NCH);
    localparam int MAX_P = BASE_CYC << ((1 << CODE_W) - 1);
    localparam int CNT_W = $clog2(MAX_P + 1);

    pace_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CHW-1:0]   ch_q;
    logic [CNT_W-1:0] period;

    assign period = CNT_W'(BASE_CYC) << delay_code;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_PACE;
            ST_PACE:   state_d = (cnt_q == '0) ? ST_LAUNCH : ST_PACE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // interval counter and channel pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ch_q  <= '0;
        end else begin
            unique case (state_q)
                ST_LAUNCH: begin
                    cnt_q <= period - CNT_W'(2);
                    ch_q  <= (ch_q >= last_ch) ? '0 : ch_q + CHW'(1);
                end
                ST_PACE:   if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

    // outputs
    always_comb begin
        conv_start = (state_q == ST_LAUNCH);
        conv_ch    = ch_q;
    end

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R1
    pace_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PACE && cnt_q == '0) |=> conv_start);

endmodule

// File: rtl/winmon_alarms.sv
module winmon_alarms #(
    parameter int NCH = 4,
    parameter int DW  = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         alarm_clr,
    input  logic                   alert_ack,
    input  logic [NCH*DW-1:0]      lo_thr,
    input  logic [NCH*DW-1:0]      hi_thr,
    input  logic                   res_valid,
    input  logic [$clog2(NCH)-1:0] res_ch,
    input  logic [DW-1:0]          res_data,
    output logic [NCH-1:0]         set_vec,
    output logic [NCH-1:0]         alarm_q
);
    localparam int CHW = $clog2(NCH);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [DW-1:0] lo_i, hi_i;
        logic          drop_i;

        assign lo_i    = lo_thr[i*DW +: DW];
        assign hi_i    = hi_thr[i*DW +: DW];
        assign set_vec[i] = res_valid && (res_ch == CHW'(i)) &&
                            ((res_data < lo_i) || (res_data > hi_i));
        assign drop_i  = alarm_clr[i] || alert_ack;

        // set takes priority over any clear
        always_ff @(posedge clk) begin
            if (!rst_n)          alarm_q[i] <= 1'b0;
            else if (set_vec[i]) alarm_q[i] <= 1'b1;
            else if (drop_i)     alarm_q[i] <= 1'b0;
        end

        // R5 R8
        alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> alarm_q[i]);

        // R7 R9
        alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (drop_i && !set_vec[i]) |=> !alarm_q[i]);

        // R6
        alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!drop_i && !set_vec[i]) |=> $stable(alarm_q[i]));
    end

endmodule

// File: rtl/winmon_irq.sv
module winmon_irq #(
    parameter int NCH = 4
) (
    input  logic           int_en,
    input  logic [NCH-1:0] alarm_q,
    output logic           irq_oe,
    output logic           irq_level
);
    always_comb begin
        irq_oe    = int_en && (|alarm_q);
        irq_level = 1'b0;
    end
endmodule

// File: rtl/winmon_ctrl.sv
module winmon_ctrl #(
    parameter int NCH      = 4,
    parameter int DW       = 10,
    parameter int BASE_CYC = 4,
    parameter int CODE_W   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CODE_W-1:0]      delay_code,
    input  logic [$clog2(NCH)-1:0] last_ch,
    input  logic                   int_en,
    input  logic [NCH-1:0]         alarm_clr,
    input  logic                   alert_ack,
    input  logic [NCH*DW-1:0]      lo_thr,
    input  logic [NCH*DW-1:0]      hi_thr,
    input  logic                   res_valid,
    input  logic [$clog2(NCH)-1:0] res_ch,
    input  logic [DW-1:0]          res_data,
    output logic                   conv_start,
    output logic [$clog2(NCH)-1:0] conv_ch,
    output logic [NCH-1:0]         alarm_stat,
    output logic                   irq_oe,
    output logic                   irq_level
);
    logic [NCH-1:0] set_vec;

    winmon_pacer #(.NCH(NCH), .BASE_CYC(BASE_CYC), .CODE_W(CODE_W)) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .delay_code (delay_code),
        .last_ch    (last_ch),
        .conv_start (conv_start),
        .conv_ch    (conv_ch)
    );

    winmon_alarms #(.NCH(NCH), .DW(DW)) u_alarms (
        .clk       (clk),
        .rst_n     (rst_n),
        .alarm_clr (alarm_clr),
        .alert_ack (alert_ack),
        .lo_thr    (lo_thr),
        .hi_thr    (hi_thr),
        .res_valid (res_valid),
        .res_ch    (res_ch),
        .res_data  (res_data),
        .set_vec   (set_vec),
        .alarm_q   (alarm_stat)
    );

    winmon_irq #(.NCH(NCH)) u_irq (
        .int_en    (int_en),
        .alarm_q   (alarm_stat),
        .irq_oe    (irq_oe),
        .irq_level (irq_level)
    );

    // R9
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_ack && set_vec == '0) |=> !irq_oe);

    // R11
    status_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(int_en) && alarm_clr == '0 && !alert_ack) |=> alarm_stat >= $past(alarm_stat));

endmodule

// File: tb/winmon_ctrl_bench.sv
module winmon_ctrl_bench;
    localparam int NCH = 4, DW = 10, BASE = 4, CODE_W = 3, CHW = 2;

    logic clk = 0, rst_n = 0;
    logic [CODE_W-1:0] delay_code = '0;
    logic [CHW-1:0]    last_ch = 2'd3;
    logic              int_en = 1'b1;
    logic [NCH-1:0]    alarm_clr = '0;
    logic              alert_ack = 1'b0;
    logic [NCH*DW-1:0] lo_thr, hi_thr;
    logic              res_valid = 1'b0;
    logic [CHW-1:0]    res_ch = '0;
    logic [DW-1:0]     res_data = '0;
    logic              conv_start;
    logic [CHW-1:0]    conv_ch;
    logic [NCH-1:0]    alarm_stat;
    logic              irq_oe, irq_level;

    int checks = 0, failures = 0, cycles = 0;
    logic [NCH-1:0] exp_al = '0;

    always #4 clk = ~clk;

    winmon_ctrl #(.NCH(NCH), .DW(DW), .BASE_CYC(BASE), .CODE_W(CODE_W)) u_winmon_ctrl (
        .clk(clk), .rst_n(rst_n), .delay_code(delay_code), .last_ch(last_ch),
        .int_en(int_en), .alarm_clr(alarm_clr), .alert_ack(alert_ack),
        .lo_thr(lo_thr), .hi_thr(hi_thr), .res_valid(res_valid), .res_ch(res_ch),
        .res_data(res_data), .conv_start(conv_start), .conv_ch(conv_ch),
        .alarm_stat(alarm_stat), .irq_oe(irq_oe), .irq_level(irq_level)
    );

    function automatic int lo_of(int c); return 100 + 10 * c; endfunction
    function automatic int hi_of(int c); return 500 + 10 * c; endfunction

    initial begin
        for (int c = 0; c < NCH; c++) begin
            lo_thr[c*DW +: DW] = DW'(lo_of(c));
            hi_thr[c*DW +: DW] = DW'(hi_of(c));
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic next_start(output int gap, output int ch);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!conv_start);
        ch = int'(conv_ch);
    endtask

    // drives one cycle of clear / ack / result, updates the model, checks alarms
    task automatic pulse(input logic [NCH-1:0] clr, input bit ack, input bit vld,
                         input int ch, input int data, input string req);
        @(negedge clk);
        alarm_clr = clr; alert_ack = ack; res_valid = vld;
        res_ch = CHW'(ch); res_data = DW'(data);
        @(negedge clk);
        alarm_clr = '0; alert_ack = 1'b0; res_valid = 1'b0;
        exp_al = exp_al & ~clr & ~(ack ? {NCH{1'b1}} : '0);
        if (vld && (data < lo_of(ch) || data > hi_of(ch))) exp_al[ch] = 1'b1;
        chk(alarm_stat == exp_al, req, int'(alarm_stat), int'(exp_al));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int gap, ch, prev, g2, exp_ch;
        repeat (3) @(negedge clk);
        // R2 / R10 reset state
        chk(conv_start == 1'b0, "R2 reset start", int'(conv_start), 0);
        chk(alarm_stat == '0, "R10 reset alarms", int'(alarm_stat), 0);
        chk(irq_oe == 1'b0, "R10 reset irq", int'(irq_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(conv_start == 1'b1 && conv_ch == 0, "R2 first start", int'(conv_start), 1);
        prev = 0;

        // R1 every delay code, two intervals each; R3 channel order with last 3
        for (int c = 0; c < 8; c++) begin
            delay_code = CODE_W'(c);
            for (int k = 0; k < 2; k++) begin
                next_start(gap, ch);
                chk(gap == (BASE << c), "R1 interval", gap, BASE << c);
                exp_ch = (prev >= 3) ? 0 : prev + 1;
                chk(ch == exp_ch, "R3 channel order", ch, exp_ch);
                prev = ch;
            end
        end

        // R4 change of code mid-interval applies from the next interval
        delay_code = 3'd2;
        next_start(gap, ch); prev = ch;
        repeat (5) @(negedge clk);
        delay_code = 3'd5;
        next_start(g2, ch); prev = ch;
        chk(g2 + 5 == (BASE << 2), "R4 old interval kept", g2 + 5, BASE << 2);
        next_start(gap, ch); prev = ch;
        chk(gap == (BASE << 5), "R4 new interval", gap, BASE << 5);

        // R3 sweep of every last channel
        delay_code = 3'd0;
        for (int l = 0; l < NCH; l++) begin
            next_start(gap, ch); prev = ch;
            last_ch = CHW'(l);
            for (int k = 0; k < 6; k++) begin
                next_start(gap, ch);
                exp_ch = (prev >= l) ? 0 : prev + 1;
                chk(ch == exp_ch, "R3 wrap sweep", ch, exp_ch);
                prev = ch;
            end
        end

        // R5 boundary sweep on every channel
        for (int c = 0; c < NCH; c++) begin
            int vals[7];
            vals = '{0, lo_of(c) - 1, lo_of(c), (lo_of(c) + hi_of(c)) / 2,
                     hi_of(c), hi_of(c) + 1, 1023};
            foreach (vals[v]) begin
                pulse({NCH{1'b1}}, 1'b0, 1'b0, 0, 0, "R7 clear all");
                pulse('0, 1'b0, 1'b1, c, vals[v], "R5 window compare");
            end
        end

        // R6 latched through in-window result
        pulse({NCH{1'b1}}, 1'b0, 1'b0, 0, 0, "R7 clear all");
        pulse('0, 1'b0, 1'b1, 1, 1023, "R5 set ch1");
        pulse('0, 1'b0, 1'b1, 1, 300, "R6 held after in-window");

        // R7 selective clear, zero bits ignored
        for (int c = 0; c < NCH; c++) pulse('0, 1'b0, 1'b1, c, 0, "R5 set all");
        pulse(4'b0101, 1'b0, 1'b0, 0, 0, "R7 clear 0 and 2");
        pulse(4'b0000, 1'b0, 1'b0, 0, 0, "R7 zero clear no effect");
        chk(alarm_stat == 4'b1010, "R7 remaining", int'(alarm_stat), 10);

        // R8 set beats clear on same channel
        pulse(4'b1100, 1'b0, 1'b1, 2, 5, "R8 set wins over clear");
        chk(alarm_stat == 4'b0110, "R8 result", int'(alarm_stat), 6);

        // R10 / R11 interrupt enable
        int_en = 1'b1; @(negedge clk);
        chk(irq_oe == 1'b1 && irq_level == 1'b0, "R10 irq driven low", int'(irq_oe), 1);
        int_en = 1'b0; @(negedge clk);
        chk(irq_oe == 1'b0, "R10 irq disabled", int'(irq_oe), 0);
        chk(alarm_stat == 4'b0110, "R11 status while disabled", int'(alarm_stat), 6);
        int_en = 1'b1; @(negedge clk);

        // R9 acknowledge clears all and releases the interrupt
        pulse('0, 1'b1, 1'b0, 0, 0, "R9 ack clears all");
        chk(irq_oe == 1'b0, "R9 irq released", int'(irq_oe), 0);
        pulse('0, 1'b0, 1'b1, 0, 1000, "R5 set ch0");
        pulse('0, 1'b1, 1'b1, 1, 0, "R9 ack with concurrent set");
        chk(alarm_stat == 4'b0010, "R9 concurrent set kept", int'(alarm_stat), 2);
        chk(irq_oe == 1'b1, "R10 irq on held alarm", int'(irq_oe), 1);
        pulse(4'b0010, 1'b0, 1'b0, 0, 0, "R7 clear last");
        chk(irq_oe == 1'b0, "R10 irq off after all clear", int'(irq_oe), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule